// File: doc/BRIEF.md
# Serial Transmitter With Completion Flags

This block turns a byte written over a simple register bus into an asynchronous serial frame on a single output line. A write to the data register is taken only while the transmit-empty flag is set. The byte is then held until the transmitter is enabled and sent as soon as the engine is idle. Two status flags, transmit-empty and transmit-complete, tell software when it may write again and when the line has gone quiet. An interrupt request is formed from each flag and its own enable.

Bit timing comes from an external divider that pulses `bit_tick` once per bit period. Once a character starts, the engine waits for the next tick before it drives the start bit, so every bit on the line lasts exactly one tick period. A frame is 10 bits long (start, 8 data, stop), or 11 bits when the long-frame select is high. In that mode a ninth data bit, taken from a control input, comes between data bit 7 and the stop bit. The enclosing chip provides the control bits as plain inputs and decodes the address down to a one-bit register select.

Top module: `sertx_unit`

## Requirements
- R1: After reset `empty_flag` = 1, `done_flag` = 1, `txd` = 1 and `irq` = 0.
- R2: A data write (`bus_wr`=1, `bus_sel`=0) while `empty_flag` = 0 is ignored: the character already in flight is sent unchanged and nothing further is sent afterwards.
- R3: A data write accepted while `xmit_en` = 1 and the line is idle starts the character at once: both flags read 0 in the cycle after the write edge.
- R4: A data write accepted while `xmit_en` = 0 leaves both flags set and the line high, and a later data write replaces the held byte. Setting `xmit_en` later starts the held byte (the last one written): both flags read 0 one clock after `xmit_en` is seen high, and the byte is sent once only.
- R5: The line idles high. At the first `bit_tick` after a start, `txd` goes low for the start bit. Each later tick then puts out one data bit, LSB first. A high stop bit follows, so each bit lasts one tick period.
- R6: With `long_frame` = 1 at the start, an extra bit equal to `bit8_val` as sampled at the start is sent after data bit 7 and before the stop bit. A later change of `bit8_val` does not alter the frame.
- R7: Both flags stay 0 for the whole frame and rise together at the tick that ends the stop bit. That is the 11th tick after the start for a 10-bit frame and the 12th for an 11-bit frame, with `txd` high from then on.
- R8: `irq` is registered and equals (`empty_ie` & `empty_flag`) | (`done_ie` & `done_flag`), using the enables seen at the previous clock edge.
- R9: A write with `bus_sel` = 1 (status register) has no effect on the flags, the line or a frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 data, 1 status |
| bus_wdata | input | 8 | Write data |
| xmit_en | input | 1 | Transmitter enable |
| empty_ie | input | 1 | Interrupt enable for the empty flag |
| done_ie | input | 1 | Interrupt enable for the complete flag |
| long_frame | input | 1 | 0: 10-bit frame, 1: 11-bit frame |
| bit8_val | input | 1 | Ninth data bit for 11-bit frames |
| bit_tick | input | 1 | One-cycle pulse per bit period from the divider |
| txd | output | 1 | Serial output line, idle high |
| empty_flag | output | 1 | Transmit data register empty |
| done_flag | output | 1 | Transmission complete |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check several things. The two flags always agree. The line is high whenever the flags are set. A fall of the flags needs the transmitter enabled, and a rise needs a bit tick. The interrupt output matches its enables and flags. The bench scenarios cover what a single-cycle property cannot see. They check the bit-by-bit content and order of 10-bit and 11-bit frames. They show that a rejected write does not replace the byte in flight, and that a byte held while the transmitter is disabled is sent exactly once. They also show that status-register writes leave everything unchanged.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_ARM  = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;

  localparam int FLAG_EMPTY = 0;
  localparam int FLAG_DONE  = 1;
  localparam int NUM_FLAGS  = 2;

endpackage

// File: rtl/sertx_frame_engine.sv
module sertx_frame_engine
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              long_i,
  input  logic              bit8_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              txd_o,
  output logic              idle_o,
  output logic              finish_o
);

  localparam int SHORT_LEN = DATA_W + 2;
  localparam int LONG_LEN  = DATA_W + 3;
  localparam int CNT_W     = $clog2(LONG_LEN);
  localparam int SH_W      = DATA_W + 2;
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_LEN - 1);

  tx_state_e        state_q;
  logic [SH_W-1:0]  shreg_q;
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] last_q;
  logic             txd_q;

  assign txd_o    = txd_q;
  assign idle_o   = (state_q == TX_IDLE);
  assign finish_o = (state_q == TX_SEND) && tick_i && (pos_q == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TX_IDLE;
      shreg_q <= '1;
      pos_q   <= '0;
      last_q  <= '0;
      txd_q   <= 1'b1;
    end else begin
      case (state_q)
        TX_IDLE: begin
          if (start_i) begin
            // stop bit above the optional ninth bit above the data
            shreg_q <= {1'b1, (long_i ? bit8_i : 1'b1), data_i};
            last_q  <= long_i ? LAST_LONG : LAST_SHORT;
            state_q <= TX_ARM;
          end
        end
        TX_ARM: begin
          if (tick_i) begin
            txd_q   <= 1'b0;
            pos_q   <= '0;
            state_q <= TX_SEND;
          end
        end
        TX_SEND: begin
          if (tick_i) begin
            if (pos_q == last_q) begin
              txd_q   <= 1'b1;
              state_q <= TX_IDLE;
            end else begin
              txd_q   <= shreg_q[0];
              shreg_q <= {1'b1, shreg_q[SH_W-1:1]};
              pos_q   <= pos_q + 1'b1;
            end
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sertx_flag_ctl.sv
module sertx_flag_ctl
  import sertx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 finish_i,
  input  logic [NUM_FLAGS-1:0] ie_i,
  output logic [NUM_FLAGS-1:0] flag_o,
  output logic                 irq_o
);

  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] flag_nxt;
  logic                 irq_q;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_comb begin
      flag_nxt[g] = flag_q[g];
      if (start_i)       flag_nxt[g] = 1'b0;
      else if (finish_i) flag_nxt[g] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) flag_q[g] <= 1'b1;
      else     flag_q[g] <= flag_nxt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(ie_i & flag_nxt);
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/sertx_unit.sv
module sertx_unit
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              xmit_en,
  input  logic              empty_ie,
  input  logic              done_ie,
  input  logic              long_frame,
  input  logic              bit8_val,
  input  logic              bit_tick,
  output logic              txd,
  output logic              empty_flag,
  output logic              done_flag,
  output logic              irq
);

  logic [DATA_W-1:0]    hold_q;
  logic                 pending_q;
  logic                 wr_ok;
  logic                 start;
  logic                 eng_idle;
  logic                 eng_finish;
  logic [DATA_W-1:0]    start_data;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] enables;

  // only the data register reacts to writes; status writes fall away here
  assign wr_ok      = bus_wr && !bus_sel && flags[FLAG_EMPTY];
  assign start      = xmit_en && eng_idle && (pending_q || wr_ok);
  assign start_data = wr_ok ? bus_wdata : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      pending_q <= 1'b0;
    end else begin
      if (wr_ok) hold_q <= bus_wdata;
      if (start)      pending_q <= 1'b0;
      else if (wr_ok) pending_q <= 1'b1;
    end
  end

  sertx_frame_engine #(.DATA_W(DATA_W)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .tick_i   (bit_tick),
    .long_i   (long_frame),
    .bit8_i   (bit8_val),
    .data_i   (start_data),
    .txd_o    (txd),
    .idle_o   (eng_idle),
    .finish_o (eng_finish)
  );

  always_comb begin
    enables             = '0;
    enables[FLAG_EMPTY] = empty_ie;
    enables[FLAG_DONE]  = done_ie;
  end

  sertx_flag_ctl u_flags (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .finish_i (eng_finish),
    .ie_i     (enables),
    .flag_o   (flags),
    .irq_o    (irq)
  );

  assign empty_flag = flags[FLAG_EMPTY];
  assign done_flag  = flags[FLAG_DONE];

endmodule

// File: rtl/sertx_unit_chk.sv
module sertx_unit_chk (
  input logic clk,
  input logic rst,
  input logic xmit_en,
  input logic empty_ie,
  input logic done_ie,
  input logic bit_tick,
  input logic txd,
  input logic empty_flag,
  input logic done_flag,
  input logic irq
);

  logic run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  p_flags_pair_r7: assert property (@(posedge clk) disable iff (rst)
    empty_flag == done_flag);

  p_line_high_r5: assert property (@(posedge clk) disable iff (rst)
    empty_flag |-> txd);

  p_start_enabled_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(empty_flag) |-> $past(xmit_en));

  p_rise_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(empty_flag) |-> $past(bit_tick));

  p_irq_match_r8: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (irq == (($past(empty_ie) && empty_flag) || ($past(done_ie) && done_flag))));

endmodule

bind sertx_unit sertx_unit_chk u_chk (.*);

// File: tb/sertx_unit_test.sv
module sertx_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_sel = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       xmit_en = 1'b0;
  logic       empty_ie = 1'b0;
  logic       done_ie = 1'b0;
  logic       long_frame = 1'b0;
  logic       bit8_val = 1'b0;
  logic       bit_tick = 1'b0;
  logic       txd;
  logic       empty_flag;
  logic       done_flag;
  logic       irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sertx_unit uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .xmit_en(xmit_en), .empty_ie(empty_ie), .done_ie(done_ie),
    .long_frame(long_frame), .bit8_val(bit8_val), .bit_tick(bit_tick),
    .txd(txd), .empty_flag(empty_flag), .done_flag(done_flag), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_sel = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic check_frame(input logic [7:0] d, input logic lng, input logic b8, input string tag);
    int   nbits;
    logic exp_bit;
    nbits = lng ? 11 : 10;
    for (int i = 0; i < nbits; i++) begin
      if (i == 0)                 exp_bit = 1'b0;
      else if (i <= 8)            exp_bit = d[i-1];
      else if (lng && i == 9)     exp_bit = b8;
      else                        exp_bit = 1'b1;
      tick_once();
      chk({tag, " R5 line bit"}, txd, exp_bit);
      chk({tag, " R7 empty low in frame"}, empty_flag, 1'b0);
    end
    tick_once();
    chk({tag, " R7 empty set at end"}, empty_flag, 1'b1);
    chk({tag, " R7 done set at end"}, done_flag, 1'b1);
    chk({tag, " R5 line idle after stop"}, txd, 1'b1);
    idle_cycles(2);
  endtask

  task automatic t_reset();
    chk("R1 empty", empty_flag, 1'b1);
    chk("R1 done", done_flag, 1'b1);
    chk("R1 txd", txd, 1'b1);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_basic();
    xmit_en = 1'b1;
    bus_write(1'b0, 8'hA5);
    chk("R3 empty drops", empty_flag, 1'b0);
    chk("R3 done drops", done_flag, 1'b0);
    chk("R5 line high before first tick", txd, 1'b1);
    check_frame(8'hA5, 1'b0, 1'b0, "basic");
  endtask

  task automatic t_held();
    xmit_en = 1'b0;
    bus_write(1'b0, 8'h3C);
    chk("R4 empty stays set", empty_flag, 1'b1);
    bus_write(1'b0, 8'h81);
    tick_once();
    chk("R4 line quiet while disabled", txd, 1'b1);
    chk("R4 done stays set", done_flag, 1'b1);
    @(negedge clk);
    xmit_en = 1'b1;
    @(negedge clk);
    chk("R4 flags drop on enable", empty_flag, 1'b0);
    check_frame(8'h81, 1'b0, 1'b0, "held R4");
    tick_once();
    tick_once();
    chk("R4 sent once line", txd, 1'b1);
    chk("R4 sent once flag", empty_flag, 1'b1);
  endtask

  task automatic t_reject();
    xmit_en = 1'b1;
    bus_write(1'b0, 8'h5A);
    bus_write(1'b0, 8'hFF);
    check_frame(8'h5A, 1'b0, 1'b0, "reject R2");
    tick_once();
    chk("R2 no second frame", txd, 1'b1);
    chk("R2 empty after", empty_flag, 1'b1);
  endtask

  task automatic t_long();
    xmit_en = 1'b1;
    long_frame = 1'b1;
    bit8_val = 1'b1;
    bus_write(1'b0, 8'h0F);
    bit8_val = 1'b0;
    check_frame(8'h0F, 1'b1, 1'b1, "long R6 b8=1");
    bit8_val = 1'b0;
    bus_write(1'b0, 8'hF0);
    bit8_val = 1'b1;
    check_frame(8'hF0, 1'b1, 1'b0, "long R6 b8=0");
    long_frame = 1'b0;
  endtask

  task automatic t_irq();
    xmit_en = 1'b1;
    @(negedge clk); empty_ie = 1'b1; done_ie = 1'b0;
    @(negedge clk);
    chk("R8 empty irq", irq, 1'b1);
    empty_ie = 1'b0; done_ie = 1'b1;
    @(negedge clk);
    chk("R8 done irq", irq, 1'b1);
    done_ie = 1'b0;
    @(negedge clk);
    chk("R8 irq off", irq, 1'b0);
    empty_ie = 1'b1;
    bus_write(1'b0, 8'h96);
    chk("R8 irq low in frame", irq, 1'b0);
    check_frame(8'h96, 1'b0, 1'b0, "irq");
    chk("R8 irq at end", irq, 1'b1);
    empty_ie = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_status();
    xmit_en = 1'b1;
    bus_write(1'b1, 8'h55);
    chk("R9 empty after status write", empty_flag, 1'b1);
    tick_once();
    chk("R9 no frame from status write", txd, 1'b1);
    bus_write(1'b0, 8'hC3);
    bus_write(1'b1, 8'h00);
    chk("R9 flags kept in frame", empty_flag, 1'b0);
    check_frame(8'hC3, 1'b0, 1'b0, "status R9");
  endtask

  initial begin
    idle_cycles(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_held();
    t_reject();
    t_long();
    t_irq();
    t_status();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule